// File: doc/BRIEF.md
# Transmit Valid-Latency and Alignment-Marker Scheduler

This block sits between a transmit encoder and a PCS sink. It takes the sink's ready indication and returns a valid strobe that is ready shifted by a fixed number of clock cycles, set by a parameter. Both edges of ready appear on valid with the same delay. Valid is not a handshake. It is the time base for everything the encoder sends.

In FEC mode the block also schedules the alignment-marker insert strobe. A period counter moves forward only in cycles where valid is high. After a set number of such cycles with the strobe low, the strobe goes high for a fixed burst of valid cycles. When valid drops, the counters and the strobe stop where they are, so no marker slot is ever moved. A parameter picks a short period for simulation or the full period for hardware. In non-FEC mode the strobe is held low. A hold output tells the encoder when its data and control words must stay frozen: while valid is low, while a marker is being inserted, and for one cycle after either.

Top module: `tx_am_sched`

## Requirements
- R1: `tx_valid_o` equals `pcs_ready_i` delayed by exactly LAT clock cycles, on both rising and falling edges. With LAT=1, a ready value sampled at one edge appears on valid right after that edge.
- R2: A LAT value outside 1 to 10 stops elaboration with an error.
- R3: With FEC_EN=1, every marker burst holds `am_insert_o` high for exactly BURST (default 4) valid cycles.
- R4: With FEC_EN=0, `am_insert_o` is 0 in every cycle.
- R5: Between the fall of the strobe and its next rise there are exactly PERIOD valid cycles with the strobe low. After reset the first burst starts once PERIOD valid cycles have passed.
- R6: SIM_MODE=1 selects PERIOD=5119 and SIM_MODE=0 selects PERIOD=81916.
- R7: In a cycle where `tx_valid_o` is 0, the strobe and the marker counters do not change. A burst interrupted by a valid drop resumes with its remaining cycles once valid returns.
- R8: `hold_o` is 1 when (`tx_valid_o`==0 or `am_insert_o`==1) holds in the current cycle or held in the previous cycle. Otherwise it is 0.
- R9: During and right after reset, `tx_valid_o`=0, `am_insert_o`=0 and `hold_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcs_ready_i | input | 1 | Ready indication from the PCS sink |
| tx_valid_o | output | 1 | Ready delayed by LAT cycles |
| am_insert_o | output | 1 | Alignment-marker insert strobe |
| hold_o | output | 1 | Freeze request to the encoder |

## Verification
The hardest case to reach is a valid drop that lands inside a four-cycle marker burst. A drop like that shows whether the burst freezes and then resumes without gaining or losing a cycle. The stimulus watches the strobe. When it first sees a burst begin, it pulls ready low at once. Because of the delay line, valid falls partway through the burst. The reference model counts valid cycles on its own, so the burst length and the period that follows are checked across this freeze. Regular ready gaps add further freezes during the long period count.

// File: rtl/tx_am_sched.sv
module tx_am_sched #(
  parameter int LAT        = 3,
  parameter bit FEC_EN     = 1'b1,
  parameter bit SIM_MODE   = 1'b1,
  parameter int BURST      = 4,
  parameter int SIM_PERIOD = 5119,
  parameter int HW_PERIOD  = 81916
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pcs_ready_i,
  output logic tx_valid_o,
  output logic am_insert_o,
  output logic hold_o
);

  localparam int PERIOD = SIM_MODE ? SIM_PERIOD : HW_PERIOD;  // R6
  localparam int CW     = $clog2(PERIOD + 1);
  localparam int BW     = $clog2(BURST + 1);

  // R2: latency range enforced at elaboration
  if (LAT < 1 || LAT > 10) begin : g_bad_lat
    $error("tx_am_sched: LAT must lie in 1..10");
  end

  logic [LAT-1:0] dly_q;
  logic           am_q;
  logic           hold_q;
  logic           hold_raw;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dly_q <= '0;
    else        dly_q <= (dly_q << 1) | LAT'(pcs_ready_i);

  assign tx_valid_o  = dly_q[LAT-1];
  assign am_insert_o = am_q;

  if (FEC_EN) begin : g_fec
    logic [CW-1:0] pcnt_q;
    logic [BW-1:0] bcnt_q;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pcnt_q <= '0;
        bcnt_q <= '0;
        am_q   <= 1'b0;
      end else if (tx_valid_o) begin
        if (am_q) begin
          if (bcnt_q == BW'(BURST - 1)) begin
            am_q   <= 1'b0;
            bcnt_q <= '0;
            pcnt_q <= '0;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end else if (pcnt_q == CW'(PERIOD - 1)) begin
          am_q   <= 1'b1;
          bcnt_q <= '0;
        end else begin
          pcnt_q <= pcnt_q + 1'b1;
        end
      end
  end else begin : g_nofec
    assign am_q = 1'b0;
  end

  assign hold_raw = ~tx_valid_o | am_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hold_q <= 1'b1;
    else        hold_q <= hold_raw;

  assign hold_o = hold_raw | hold_q;

  // checker state
  logic [3:0]    since_rst_q;
  logic [BW:0]   run_q;
  logic [CW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      since_rst_q <= '0;
      run_q       <= '0;
      gap_q       <= '0;
    end else begin
      if (since_rst_q != 4'hF) since_rst_q <= since_rst_q + 1'b1;
      if (!am_insert_o)    run_q <= '0;
      else if (tx_valid_o) run_q <= run_q + 1'b1;
      if (am_insert_o)     gap_q <= '0;
      else if (tx_valid_o) gap_q <= gap_q + 1'b1;
    end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst_q >= 4'(LAT)) |-> (tx_valid_o == $past(pcs_ready_i, LAT)));

  assert_burst_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= (BW+1)'(BURST));

  assert_burst_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(am_insert_o) |-> (run_q == (BW+1)'(BURST)));

  assert_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(am_insert_o) |-> (gap_q == CW'(PERIOD)));

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid_o |=> $stable(am_insert_o));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid_o || am_insert_o) |=> hold_o);

  always_comb
    if (!FEC_EN) assert_nofec_R4: assert (!am_insert_o);

endmodule

// File: tb/tx_am_sched_tb.sv
`timescale 1ns/1ps
module tx_am_sched_tb_top;
  localparam int LAT = 3;
  localparam int P   = 5119;
  localparam int B   = 4;

  logic clk = 1'b0, rst_n = 1'b0, ready = 1'b0;
  logic v, am, hold, nf_v, nf_am, nf_hold;
  always #4 clk = ~clk;

  tx_am_sched #(.LAT(LAT), .FEC_EN(1'b1), .SIM_MODE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .pcs_ready_i(ready),
    .tx_valid_o(v), .am_insert_o(am), .hold_o(hold));

  tx_am_sched #(.LAT(1), .FEC_EN(1'b0), .SIM_MODE(1'b0)) dut_nf (
    .clk(clk), .rst_n(rst_n), .pcs_ready_i(ready),
    .tx_valid_o(nf_v), .am_insert_o(nf_am), .hold_o(nf_hold));

  int checks = 0, fails = 0;
  bit finished = 0;

  bit q[$];
  int m_cnt, m_b;
  bit m_am, m_valid, m_hprev, nf_exp;

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q = {};
      for (int k = 0; k < LAT; k++) q.push_back(1'b0);
      m_cnt = 0; m_b = 0; m_am = 0; m_valid = 0; m_hprev = 1; nf_exp = 0;
    end else begin
      m_hprev = !m_valid || m_am;
      if (m_valid) begin
        if (m_am) begin
          m_b++;
          if (m_b == B) begin m_am = 0; m_b = 0; m_cnt = 0; end
        end else begin
          m_cnt++;
          if (m_cnt == P) m_am = 1;
        end
      end
      q.push_back(ready);
      void'(q.pop_front());
      m_valid = q[0];
      nf_exp = ready;
    end
  end

  int bursts = 0, frozen_seen = 0;
  bit am_prev = 0;

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R1", "valid", v, m_valid);
    chk("R5/R6", "am strobe", am, m_am);
    chk("R8", "hold", hold, (!m_valid || m_am) || m_hprev);
    chk("R4", "nofec am", nf_am, 1'b0);
    chk("R1", "lat1 valid", nf_v, nf_exp);
    if (am && !am_prev) bursts++;
    if (am && !v) frozen_seen++;
    am_prev = am;
  end

  initial begin
    #(8*120000);
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int stall;
    bit stall_done;
    stall = 0; stall_done = 0;
    repeat (5) @(negedge clk);
    chk("R9", "reset valid", v, 1'b0);
    chk("R9", "reset am", am, 1'b0);
    chk("R9", "reset hold", hold, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "post-reset hold", hold, 1'b1);
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if (am && !stall_done) begin stall = 6; stall_done = 1; end
      if (stall > 0) begin ready = 1'b0; stall--; end
      else ready = (i > 8) && ((i % 211) < 204);
    end
    repeat (LAT + 2) @(negedge clk);
    finished = 1;
    checks++;
    if (bursts < 4) begin fails++; $display("FAIL R5 bursts: actual=%0d expected>=4", bursts); end
    checks++;
    if (frozen_seen == 0) begin fails++; $display("FAIL R7 frozen burst: actual=0 expected>0"); end
    checks++;
    if (frozen_seen == 0 && bursts == 0) begin fails++; $display("FAIL R3 no burst: actual=0 expected>0"); end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule